// File: doc/BRIEF.md
# Iterative 64-Bit Two-Column Block Cipher

This block enciphers or deciphers one 64-bit block at a time. It treats the block as two 32-bit columns. Each round applies the byte substitution to all eight bytes. It then applies the column mixing transform to each column on its own. Before every substitution step a fixed byte interleave swaps alternate bytes between the two columns, so one column's bytes reach the other within a single round. The block runs fifteen rounds by default, one round per clock cycle. Both columns are processed side by side.

A client places a block on `din`, selects the direction with `decrypt` and pulses `start` while the block is idle. The block drives `key_idx` and expects the matching 64-bit round key on `key_in` in the same cycle, combinationally, from a key store outside the block. For deciphering the block reads the keys in reverse index order. It applies the inverse column transform to the middle keys itself, so one key table serves both directions. The result appears on `dout` when `done` pulses and stays there until the next accepted start.

Top module: `cipher64_iter`

## Requirements
- R1: After reset `busy` and `done` are low and `dout` is all zero.
- R2: The interleave maps the column pair (w0, w1) to (n0, n1). n0 takes bytes 3 and 1 of w1 and bytes 2 and 0 of w0; n1 takes bytes 3 and 1 of w0 and bytes 2 and 0 of w1, where byte 3 is bits 31:24. So (0x00112233, 0xaabbccdd) becomes (0xaa11cc33, 0x00bb22dd).
- R3: Word w0 is bits 63:32 and w1 is bits 31:0 of a block, and each column's first byte is bits 31:24. Enciphering gives: XOR key 0; then for rounds r = 1..N-1: interleave, substitute, column mix, XOR key r; then round N: interleave, substitute, XOR key N.
- R4: Deciphering is the exact inverse of R3 under the same key table, so deciphering an enciphered block returns the original block.
- R5: `start` while idle is accepted on that clock edge. `busy` is then high for exactly NUM_ROUNDS cycles. `done` is high for one cycle, the cycle right after `busy` falls.
- R6: `start` while `busy` is high is ignored: it changes neither the result nor the timing.
- R7: While idle, `key_idx` is NUM_ROUNDS if `decrypt` is high and 0 otherwise. During round r it is r when enciphering and NUM_ROUNDS-r when deciphering.
- R8: While idle and without an accepted start, `dout` holds its value whatever `din`, `decrypt` and `key_in` do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation on `din` when idle |
| decrypt | input | 1 | 1 selects deciphering, sampled with `start` |
| din | input | 64 | Input block |
| key_idx | output | KEY_IDX_W | Index of the round key wanted this cycle |
| key_in | input | 64 | Round key for `key_idx`, same cycle |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: `dout` holds a new result |
| dout | output | 64 | Result block |

## Verification
The bench targets the interleave vector, the first and last rounds, and key ordering in both directions. A swapped interleave byte or a missed final-round mix bypass changes every ciphertext. A decipher path that used untransformed middle keys or applied the interleave at the wrong point fails the round trip. An off-by-one round counter moves `done` and shifts `key_idx` by a cycle. Starts issued while busy, and a new start in the cycle that `done` is high, expose a controller that restarts early or drops the back-to-back request.

// File: rtl/cipher64_pkg.sv
package cipher64_pkg;

    localparam int BLK_W   = 64;
    localparam int WORD_W  = 32;
    localparam int N_COLS  = BLK_W / WORD_W;
    localparam int N_LANES = BLK_W / 8;

    typedef logic [7:0]        byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // w0 occupies the upper half of the block
    typedef struct packed {
        word_t w0;
        word_t w1;
    } blk_t;

    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_RUN  = 1'b1
    } ctl_e;

    localparam byte_t AFF_CONST     = 8'h63;
    localparam byte_t INV_AFF_CONST = 8'h05;
    localparam byte_t GF_POLY_LOW   = 8'h1b;

    function automatic byte_t gf_x2(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? GF_POLY_LOW : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t acc;
        byte_t sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_x2(sh);
        end
        return acc;
    endfunction

    // a^254 in GF(2^8); zero maps to zero
    function automatic byte_t gf_inv(byte_t a);
        byte_t p;
        byte_t r;
        p = a;
        r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic byte_t fwd_affine(byte_t a);
        return a ^ {a[6:0], a[7]} ^ {a[5:0], a[7:6]} ^ {a[4:0], a[7:5]}
                 ^ {a[3:0], a[7:4]} ^ AFF_CONST;
    endfunction

    function automatic byte_t inv_affine(byte_t a);
        return {a[6:0], a[7]} ^ {a[4:0], a[7:5]} ^ {a[1:0], a[7:2]} ^ INV_AFF_CONST;
    endfunction

    // column transform; byte 0 of the column is bits 31:24
    function automatic word_t mix_word(word_t w, logic inverse);
        byte_t b [4];
        byte_t c [4];
        byte_t y [4];
        for (int i = 0; i < 4; i++) b[i] = w[31-8*i -: 8];
        if (inverse) begin
            c[0] = 8'h0e; c[1] = 8'h0b; c[2] = 8'h0d; c[3] = 8'h09;
        end else begin
            c[0] = 8'h02; c[1] = 8'h03; c[2] = 8'h01; c[3] = 8'h01;
        end
        for (int i = 0; i < 4; i++) begin
            y[i] = 8'h00;
            for (int j = 0; j < 4; j++) begin
                y[i] = y[i] ^ gf_mul(c[(j - i + 4) % 4], b[j]);
            end
        end
        return {y[0], y[1], y[2], y[3]};
    endfunction

    // byte exchange between columns; an involution
    function automatic blk_t blk_interleave(blk_t s);
        blk_t n;
        n.w0 = {s.w1[31:24], s.w0[23:16], s.w1[15:8], s.w0[7:0]};
        n.w1 = {s.w0[31:24], s.w1[23:16], s.w0[15:8], s.w1[7:0]};
        return n;
    endfunction

endpackage

// File: rtl/sbox_lane.sv
module sbox_lane
    import cipher64_pkg::*;
(
    input  logic  inverse,
    input  byte_t lane_in,
    output byte_t lane_out
);
    byte_t pre_map;
    byte_t inv_val;

    // one shared field inverter serves both directions
    always_comb begin
        pre_map  = inverse ? inv_affine(lane_in) : lane_in;
        inv_val  = gf_inv(pre_map);
        lane_out = inverse ? inv_val : fwd_affine(inv_val);
    end
endmodule

// File: rtl/column_mixer.sv
module column_mixer
    import cipher64_pkg::*;
(
    input  logic  inverse,
    input  logic  bypass,
    input  word_t col_in,
    output word_t col_out
);
    word_t mixed;

    always_comb begin
        mixed   = mix_word(col_in, inverse);
        col_out = bypass ? col_in : mixed;
    end
endmodule

// File: rtl/round_path.sv
module round_path
    import cipher64_pkg::*;
(
    input  logic             decrypt,
    input  logic             last,
    input  blk_t             state_in,
    input  blk_t             rkey,
    output blk_t             state_out
);
    blk_t             pre_sub;
    blk_t             post_sub;
    blk_t             sub_blk;
    logic [BLK_W-1:0] pre_vec;
    logic [BLK_W-1:0] sub_vec;
    logic [BLK_W-1:0] mix_in_vec;
    logic [BLK_W-1:0] mix_out_vec;

    // encipher interleaves before substitution, decipher after
    always_comb begin
        pre_sub = decrypt ? state_in : blk_interleave(state_in);
        pre_vec = pre_sub;
    end

    for (genvar li = 0; li < N_LANES; li++) begin : g_lane
        sbox_lane u_lane (
            .inverse  (decrypt),
            .lane_in  (pre_vec[8*li +: 8]),
            .lane_out (sub_vec[8*li +: 8])
        );
    end

    always_comb begin
        sub_blk    = sub_vec;
        post_sub   = decrypt ? blk_interleave(sub_blk) : sub_blk;
        mix_in_vec = post_sub;
    end

    for (genvar ci = 0; ci < N_COLS; ci++) begin : g_col
        column_mixer u_mix (
            .inverse (decrypt),
            .bypass  (last),
            .col_in  (mix_in_vec[WORD_W*ci +: WORD_W]),
            .col_out (mix_out_vec[WORD_W*ci +: WORD_W])
        );
    end

    assign state_out = mix_out_vec ^ rkey;
endmodule

// File: rtl/key_prep.sv
module key_prep
    import cipher64_pkg::*;
(
    input  logic             decrypt,
    input  logic             middle,
    input  logic [BLK_W-1:0] key_raw,
    output blk_t             key_out
);
    logic             pass;
    logic [BLK_W-1:0] key_vec;

    // middle decipher keys go through the inverse column transform
    assign pass = !(decrypt && middle);

    for (genvar ci = 0; ci < N_COLS; ci++) begin : g_kcol
        column_mixer u_kmix (
            .inverse (1'b1),
            .bypass  (pass),
            .col_in  (key_raw[WORD_W*ci +: WORD_W]),
            .col_out (key_vec[WORD_W*ci +: WORD_W])
        );
    end

    assign key_out = key_vec;
endmodule

// File: rtl/round_ctrl.sv
module round_ctrl
    import cipher64_pkg::*;
#(
    parameter  int NUM_ROUNDS = 15,
    localparam int CW         = $clog2(NUM_ROUNDS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          decrypt_in,
    output logic          load,
    output logic          step,
    output logic          last,
    output logic          middle,
    output logic          mode,
    output logic [CW-1:0] key_idx,
    output logic          busy,
    output logic          done
);
    localparam logic [CW-1:0] LAST_RND = CW'(NUM_ROUNDS);

    ctl_e          st_q;
    logic [CW-1:0] rnd_q;
    logic          mode_q;
    logic          done_q;

    always_comb begin
        load   = (st_q == CTL_IDLE) && start;
        step   = (st_q == CTL_RUN);
        last   = step && (rnd_q == LAST_RND);
        middle = step && !last;
        if (!step) key_idx = decrypt_in ? LAST_RND : '0;
        else       key_idx = mode_q ? (LAST_RND - rnd_q) : rnd_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= CTL_IDLE;
            rnd_q  <= '0;
            mode_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                CTL_IDLE: begin
                    if (start) begin
                        st_q   <= CTL_RUN;
                        rnd_q  <= CW'(1);
                        mode_q <= decrypt_in;
                    end
                end
                default: begin
                    if (rnd_q == LAST_RND) begin
                        st_q   <= CTL_IDLE;
                        rnd_q  <= '0;
                        done_q <= 1'b1;
                    end else begin
                        rnd_q  <= rnd_q + CW'(1);
                    end
                end
            endcase
        end
    end

    assign mode = mode_q;
    assign busy = step;
    assign done = done_q;
endmodule

// File: rtl/cipher64_iter.sv
module cipher64_iter
    import cipher64_pkg::*;
#(
    parameter  int NUM_ROUNDS = 15,
    localparam int KEY_IDX_W  = $clog2(NUM_ROUNDS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 decrypt,
    input  logic [63:0]          din,
    output logic [KEY_IDX_W-1:0] key_idx,
    input  logic [63:0]          key_in,
    output logic                 busy,
    output logic                 done,
    output logic [63:0]          dout
);
    logic load;
    logic step;
    logic last;
    logic middle;
    logic mode;
    blk_t rkey;
    blk_t st_q;
    blk_t st_next;

    round_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .decrypt_in (decrypt),
        .load       (load),
        .step       (step),
        .last       (last),
        .middle     (middle),
        .mode       (mode),
        .key_idx    (key_idx),
        .busy       (busy),
        .done       (done)
    );

    key_prep u_kprep (
        .decrypt (mode),
        .middle  (middle),
        .key_raw (key_in),
        .key_out (rkey)
    );

    round_path u_round (
        .decrypt   (mode),
        .last      (last),
        .state_in  (st_q),
        .rkey      (rkey),
        .state_out (st_next)
    );

    // the state register doubles as the result register
    always_ff @(posedge clk) begin
        if (rst)       st_q <= '0;
        else if (load) st_q <= din ^ key_in;
        else if (step) st_q <= st_next;
    end

    assign dout = st_q;
endmodule

// File: rtl/cipher64_iter_chk.sv
module cipher64_iter_chk #(
    parameter  int NUM_ROUNDS = 15,
    localparam int KW         = $clog2(NUM_ROUNDS + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [63:0]   dout,
    input logic [KW-1:0] key_idx
);
    int busy_cnt;

    always_ff @(posedge clk) begin
        if (rst)       busy_cnt <= 0;
        else if (busy) busy_cnt <= busy_cnt + 1;
        else           busy_cnt <= 0;
    end

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_busy_end_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (busy_cnt == NUM_ROUNDS));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(dout));

    p_keyidx_bound_r7: assert property (@(posedge clk) disable iff (rst)
        int'(key_idx) <= NUM_ROUNDS);

    p_keyidx_step_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |->
            (key_idx == $past(key_idx) + 1'b1 || key_idx == $past(key_idx) - 1'b1));
endmodule

bind cipher64_iter cipher64_iter_chk #(.NUM_ROUNDS(NUM_ROUNDS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .dout    (dout),
    .key_idx (key_idx)
);

// File: tb/cipher64_iter_bench.sv
module cipher64_iter_bench;
    localparam int NR = 15;
    localparam int KW = $clog2(NR + 1);

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic          decrypt;
    logic [63:0]   din;
    logic [KW-1:0] key_idx;
    logic [63:0]   key_in;
    logic          busy;
    logic          done;
    logic [63:0]   dout;

    logic [63:0] key_tab [0:NR];
    logic [7:0]  t_sb  [256];
    logic [7:0]  t_isb [256];

    int n_chk = 0;
    int n_fail = 0;
    bit chk_en = 0;
    bit timed_out = 0;

    // reference model state
    bit          m_busy, m_done, m_dec;
    int          m_left;
    logic [63:0] m_out, m_pend;

    always #4 clk = ~clk;

    assign key_in = key_tab[key_idx];

    cipher64_iter #(.NUM_ROUNDS(NR)) u_cipher64_iter (
        .clk(clk), .rst(rst), .start(start), .decrypt(decrypt), .din(din),
        .key_idx(key_idx), .key_in(key_in), .busy(busy), .done(done), .dout(dout)
    );

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] b_mul(logic [7:0] a, logic [7:0] b);
        int x = a, y = b, r = 0;
        while (y != 0) begin
            if (y & 1) r = r ^ x;
            x = x << 1;
            if (x & 'h100) x = x ^ 'h11b;
            y = y >> 1;
        end
        return r[7:0];
    endfunction

    function automatic int rot8(int q, int n);
        return ((q << n) | (q >> (8 - n))) & 'hff;
    endfunction

    task automatic build_tables();
        int p = 1, q = 1, x;
        do begin
            p = (p ^ (p << 1) ^ (((p & 'h80) != 0) ? 'h1b : 0)) & 'hff;
            q = q ^ (q << 1);
            q = q ^ (q << 2);
            q = q ^ (q << 4);
            q = q & 'hff;
            if (q & 'h80) q = q ^ 'h09;
            x = q ^ rot8(q, 1) ^ rot8(q, 2) ^ rot8(q, 3) ^ rot8(q, 4) ^ 'h63;
            t_sb[p] = x[7:0];
        end while (p != 1);
        t_sb[0] = 8'h63;
        for (int i = 0; i < 256; i++) t_isb[t_sb[i]] = i[7:0];
    endtask

    function automatic logic [31:0] b_mix(logic [31:0] w, bit inv);
        logic [7:0] a0 = w[31:24], a1 = w[23:16], a2 = w[15:8], a3 = w[7:0];
        logic [7:0] y0, y1, y2, y3;
        if (!inv) begin
            y0 = b_mul(2, a0) ^ b_mul(3, a1) ^ a2 ^ a3;
            y1 = a0 ^ b_mul(2, a1) ^ b_mul(3, a2) ^ a3;
            y2 = a0 ^ a1 ^ b_mul(2, a2) ^ b_mul(3, a3);
            y3 = b_mul(3, a0) ^ a1 ^ a2 ^ b_mul(2, a3);
        end else begin
            y0 = b_mul(14, a0) ^ b_mul(11, a1) ^ b_mul(13, a2) ^ b_mul(9, a3);
            y1 = b_mul(9, a0) ^ b_mul(14, a1) ^ b_mul(11, a2) ^ b_mul(13, a3);
            y2 = b_mul(13, a0) ^ b_mul(9, a1) ^ b_mul(14, a2) ^ b_mul(11, a3);
            y3 = b_mul(11, a0) ^ b_mul(13, a1) ^ b_mul(9, a2) ^ b_mul(14, a3);
        end
        return {y0, y1, y2, y3};
    endfunction

    function automatic logic [63:0] b_il(logic [63:0] s);
        logic [31:0] w0 = s[63:32], w1 = s[31:0];
        return {(w1 & 32'hff00ff00) | (w0 & 32'h00ff00ff),
                (w0 & 32'hff00ff00) | (w1 & 32'h00ff00ff)};
    endfunction

    function automatic logic [63:0] b_sub(logic [63:0] s, bit inv);
        logic [63:0] r;
        for (int i = 0; i < 8; i++) r[8*i +: 8] = inv ? t_isb[s[8*i +: 8]] : t_sb[s[8*i +: 8]];
        return r;
    endfunction

    function automatic logic [63:0] ref_enc(logic [63:0] p);
        logic [63:0] s = p ^ key_tab[0];
        for (int r = 1; r <= NR; r++) begin
            s = b_sub(b_il(s), 0);
            if (r < NR) s = {b_mix(s[63:32], 0), b_mix(s[31:0], 0)};
            s = s ^ key_tab[r];
        end
        return s;
    endfunction

    function automatic logic [63:0] ref_dec(logic [63:0] c);
        logic [63:0] s = c;
        for (int r = NR; r >= 1; r--) begin
            s = s ^ key_tab[r];
            if (r < NR) s = {b_mix(s[63:32], 1), b_mix(s[31:0], 1)};
            s = b_il(b_sub(s, 1));
        end
        return s ^ key_tab[0];
    endfunction

    // one clock: compare outputs, then advance the model at the edge
    task automatic cycle();
        int exp_idx;
        #2;
        if (chk_en) begin
            chk(busy == m_busy, "R5 busy", 64'(busy), 64'(m_busy));
            chk(done == m_done, "R5 done", 64'(done), 64'(m_done));
            if (!m_busy) exp_idx = decrypt ? NR : 0;
            else exp_idx = m_dec ? (m_left - 1) : (NR - m_left + 1);
            chk(int'(key_idx) == exp_idx, "R7 key_idx", 64'(key_idx), 64'(exp_idx));
            if (!m_busy)
                chk(dout == m_out, m_done ? (m_dec ? "R4 result" : "R3 result") : "R8 hold",
                    dout, m_out);
        end
        @(posedge clk);
        m_done = 0;
        if (m_busy) begin
            m_left--;
            if (m_left == 0) begin
                m_busy = 0;
                m_done = 1;
                m_out  = m_pend;
            end
        end else if (start) begin
            m_busy = 1;
            m_left = NR;
            m_dec  = decrypt;
            m_pend = decrypt ? ref_dec(din) : ref_enc(din);
        end
        @(negedge clk);
    endtask

    task automatic run_op(bit d, logic [63:0] x, output logic [63:0] res);
        start = 1; decrypt = d; din = x;
        cycle();
        start = 0; din = {$urandom, $urandom}; decrypt = ~d;
        repeat (NR) cycle();
        res = dout;
    endtask

    task automatic run_all();
        logic [63:0] c, p, r, pts[6];
        typedef struct packed { logic [31:0] a; logic [31:0] b; } pair_t;
        pair_t v;
        rst = 1; start = 0; decrypt = 0; din = '0;
        build_tables();
        for (int i = 0; i <= NR; i++) key_tab[i] = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        rst = 0;
        m_busy = 0; m_done = 0; m_dec = 0; m_left = 0; m_out = '0; m_pend = '0;
        #2;
        chk(!busy && !done && dout == 64'd0, "R1 reset", {busy, done, dout[61:0]}, 64'd0);
        chk_en = 1;
        cycle();

        // R2: interleave vector, design function and bench model
        v = cipher64_pkg::blk_interleave({32'h00112233, 32'haabbccdd});
        chk(v == {32'haa11cc33, 32'h00bb22dd}, "R2 interleave", v, {32'haa11cc33, 32'h00bb22dd});
        chk(b_il({32'h00112233, 32'haabbccdd}) == {32'haa11cc33, 32'h00bb22dd}, "R2 model",
            b_il({32'h00112233, 32'haabbccdd}), {32'haa11cc33, 32'h00bb22dd});

        // R3/R4: several patterns, each enciphered then deciphered
        pts[0] = 64'h0; pts[1] = '1; pts[2] = 64'h0011223344556677;
        for (int i = 3; i < 6; i++) pts[i] = {$urandom, $urandom};
        for (int i = 0; i < 6; i++) begin
            run_op(0, pts[i], c);
            chk(c == ref_enc(pts[i]), "R3 encipher", c, ref_enc(pts[i]));
            run_op(1, c, p);
            chk(p == pts[i], "R4 round trip", p, pts[i]);
        end

        // R4: decipher of arbitrary data
        p = {$urandom, $urandom};
        run_op(1, p, r);
        chk(r == ref_dec(p), "R4 decipher", r, ref_dec(p));

        // R6: starts while busy are ignored
        p = {$urandom, $urandom};
        start = 1; decrypt = 0; din = p;
        cycle();
        for (int i = 0; i < NR; i++) begin
            start = i[0]; decrypt = ~i[0]; din = {$urandom, $urandom};
            cycle();
        end
        start = 0;
        chk(dout == ref_enc(p), "R6 busy start ignored", dout, ref_enc(p));

        // R8: idle with moving inputs
        for (int i = 0; i < 6; i++) begin
            decrypt = i[0]; din = {$urandom, $urandom};
            cycle();
        end
        chk(dout == ref_enc(p), "R8 idle hold", dout, ref_enc(p));
        repeat (3) cycle();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (200000) @(posedge clk);
                timed_out = 1;
            end
        join_any
        disable fork;
        if (timed_out) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule